// File: doc/BRIEF.md
# CPU Exception and Interrupt Entry Sequencer

This block carries out the architectural side effects of entering an event handler on a 32-bit CPU. Four kinds of event are handled: general exceptions, traps, TLB-miss exceptions and maskable interrupts. A manual reset request is also handled. The block owns the status register, the vector base register and two banks of eight general registers. It takes the current PC, R15 and a delay-slot flag from the pipeline. On an accepted event it saves the return state (saved PC, saved status, saved stack pointer) in one clock edge. It then records the event code and raises a one-cycle redirect carrying the handler address.

The status register holds the privilege, block and bank-select bits, an interrupt mask, an FPU-disable bit and four condition flags. The condition flags are kept as separate state bits and are merged back into the status word whenever it is read or saved. The bank-select bit chooses which of the two register banks appears at indices 0 to 7. The other bank is visible at indices 8 to 15. Any status write that flips the bank-select bit therefore exchanges the two sets of eight registers. When an exception arrives while the vector base is zero, no handler address can be formed. The sequencer then raises a sticky halt instead of vectoring.

Top module: `exc_entry_seq`

## Requirements
- R1: After rst_ni the status word reads 0x700000F0, the vector base is 0, new_pc_o is 0xA0000000, next_pc_o is 0xA0000002, expevt_o, spc_o, ssr_o and sgr_o are 0, and halt_o and redirect_o are low.
- R2: A general exception (exc_kind_i 0 or 3) with a non-zero vector base has the following effects one edge later:
  - spc_o takes pc_i, ssr_o takes the status word, sgr_o takes r15_i and expevt_o takes exc_code_i.
  - new_pc_o becomes vbr_o+0x100 and next_pc_o becomes new_pc_o+2.
  - Status bits 30, 29 and 28 are set.
  - redirect_o pulses for one cycle.
- R3: A TLB-miss exception (exc_kind_i 2) behaves as R2 but vectors to vbr_o+0x400.
- R4: A trap (exc_kind_i 1) behaves as R2. In addition, tra_o takes trap_imm_i shifted left by 2.
- R5: An exception raised with delay_slot_i high saves pc_i-2 in spc_o and pulses delay_clear_o with the redirect. An interrupt ignores delay_slot_i and never pulses delay_clear_o.
- R6: An exception of any kind raised while the vector base is 0 sets halt_o. It changes no saved register, code register, PC or status bit, and it leaves redirect_o low. While halt_o is high, exception and interrupt requests are ignored.
- R7: An accepted interrupt has the following effects:
  - It saves spc_o, ssr_o and sgr_o as in R2 and writes irq_code_i to intevt_o.
  - expevt_o is left unchanged.
  - new_pc_o becomes vbr_o+0x600 and status bits 30, 29 and 28 are set.
- R8: A reset request has the following effects:
  - expevt_o takes reset_code_i, the vector base is cleared and new_pc_o becomes 0xA0000000.
  - The status word becomes (old | 0x700000F0) with bit 15 cleared.
  - halt_o is cleared.
  - The vector base is not checked.
- R9: Priority is reset request, then exception, then interrupt. A losing request in the same cycle has no effect.
- R10: A status write stores sr_wdata_i masked by 0x700083F3. T, S, Q and M read back at bits 0, 1, 8 and 9. The write is ignored in a cycle where a reset request is present, or where an exception or interrupt is present while not halted.
- R11: gpr_rdata_o returns the active bank for gpr_ridx_i 0 to 7 and the other bank for 8 to 15. The active bank is selected by status bit 29. Writes go to the bank active before the edge. Any status change that flips bit 29 exchanges the two sets as seen at the ports.
- R12: A vector-base write takes effect at the next edge unless a reset request is present. An exception in the same cycle vectors from the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the current instruction |
| delay_slot_i | input | 1 | Current instruction sits in a delay slot |
| r15_i | input | 32 | Current stack pointer |
| reset_req_i | input | 1 | Manual reset request |
| reset_code_i | input | 12 | Event code recorded by a reset request |
| exc_req_i | input | 1 | Exception request |
| exc_kind_i | input | 2 | 0 general, 1 trap, 2 TLB miss, 3 general |
| exc_code_i | input | 12 | Exception event code |
| trap_imm_i | input | 8 | Trap number |
| irq_req_i | input | 1 | Interrupt request (already arbitrated) |
| irq_code_i | input | 12 | Interrupt event code |
| sr_we_i | input | 1 | Status register write |
| sr_wdata_i | input | 32 | Status write data |
| vbr_we_i | input | 1 | Vector base write |
| vbr_wdata_i | input | 32 | Vector base write data |
| gpr_we_i | input | 1 | Banked register write |
| gpr_widx_i | input | 3 | Banked register write index (active bank) |
| gpr_wdata_i | input | 32 | Banked register write data |
| gpr_ridx_i | input | 4 | Read index: 0-7 active bank, 8-15 other bank |
| gpr_rdata_o | output | 32 | Read data |
| sr_o | output | 32 | Composed status word |
| vbr_o | output | 32 | Vector base |
| redirect_o | output | 1 | One-cycle pulse: fetch from new_pc_o |
| new_pc_o | output | 32 | Handler address |
| next_pc_o | output | 32 | Handler address plus 2 |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved status |
| sgr_o | output | 32 | Saved stack pointer |
| expevt_o | output | 12 | Exception and reset event code |
| intevt_o | output | 12 | Interrupt event code |
| tra_o | output | 10 | Trap number shifted left by 2 |
| halt_o | output | 1 | Sticky halt from an exception with vector base 0 |
| delay_clear_o | output | 1 | Pulse: the delay-slot flag must be cleared |

## Verification
The hardest state to reach is the halted one. It needs a zero vector base at the moment an exception arrives. From there the bench must show that later exceptions, interrupts and the RB-driven bank exchange stay quiet until a reset request. Directed steps write the vector base to zero and raise exceptions and interrupts while halted, then release with a reset request. In the random phase about one vector-base write in eight carries zero, so halt entry and exit recur among bank flips, simultaneous requests and delay-slot exceptions.

// File: rtl/esq_pkg.sv
package esq_pkg;
  parameter int unsigned XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  localparam word_t SR_MASK      = 32'h7000_83F3;
  localparam word_t SR_RESET     = 32'h7000_00F0;
  localparam word_t SR_EVENT_SET = 32'h7000_0000;
  localparam word_t SR_IMASK     = 32'h0000_00F0;
  localparam word_t SR_FD        = 32'h0000_8000;
  localparam int    SR_RB_BIT    = 29;
  localparam int    SR_T_BIT     = 0;
  localparam int    SR_S_BIT     = 1;
  localparam int    SR_Q_BIT     = 8;
  localparam int    SR_M_BIT     = 9;
  localparam word_t FLAG_BITS    = 32'h0000_0303;

  localparam word_t RESET_PC     = 32'hA000_0000;
  localparam word_t VEC_GENERAL  = 32'h0000_0100;
  localparam word_t VEC_TLB      = 32'h0000_0400;
  localparam word_t VEC_IRQ      = 32'h0000_0600;

  typedef enum logic [1:0] {
    KIND_GEN  = 2'd0,
    KIND_TRAP = 2'd1,
    KIND_TLB  = 2'd2,
    KIND_GEN2 = 2'd3
  } exc_kind_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_RESET,
    ACT_EXC,
    ACT_IRQ,
    ACT_HALT
  } act_e;
endpackage

// File: rtl/esq_status.sv
module esq_status
  import esq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  word_t wr_data_i,
  output word_t sr_o,
  output logic  rb_o
);
  word_t rest_q;
  logic  t_q, s_q, m_q, q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rest_q <= SR_RESET & ~FLAG_BITS;
      t_q    <= 1'b0;
      s_q    <= 1'b0;
      m_q    <= 1'b0;
      q_q    <= 1'b0;
    end else if (wr_en_i) begin
      rest_q <= wr_data_i & SR_MASK & ~FLAG_BITS;
      t_q    <= wr_data_i[SR_T_BIT];
      s_q    <= wr_data_i[SR_S_BIT];
      m_q    <= wr_data_i[SR_M_BIT];
      q_q    <= wr_data_i[SR_Q_BIT];
    end
  end

  // flags live apart from the word; merge on every read
  always_comb begin
    sr_o           = rest_q;
    sr_o[SR_T_BIT] = t_q;
    sr_o[SR_S_BIT] = s_q;
    sr_o[SR_M_BIT] = m_q;
    sr_o[SR_Q_BIT] = q_q;
  end

  assign rb_o = rest_q[SR_RB_BIT];

  AST_FLAG_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (sr_o[SR_T_BIT] == $past(wr_data_i[SR_T_BIT])) &&
                (sr_o[SR_M_BIT] == $past(wr_data_i[SR_M_BIT]))); // R10
endmodule

// File: rtl/esq_gpr_bank.sv
module esq_gpr_bank
  import esq_pkg::*;
#(
  parameter int NUM_BANKED = 8,
  localparam int IDX_W = $clog2(NUM_BANKED)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rb_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  word_t            wdata_i,
  input  logic [IDX_W:0]   ridx_i,
  output word_t            rdata_o
);
  word_t bank_q [2][NUM_BANKED];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NUM_BANKED; i++) bank_q[b][i] <= '0;
      end else if (we_i && (rb_i == 1'(b))) begin
        bank_q[b][widx_i] <= wdata_i;
      end
    end
  end

  // bank select follows RB; upper index half reads the inactive set
  logic rsel;
  assign rsel    = ridx_i[IDX_W] ^ rb_i;
  assign rdata_o = bank_q[rsel][ridx_i[IDX_W-1:0]];
endmodule

// File: rtl/esq_arb.sv
module esq_arb
  import esq_pkg::*;
(
  input  logic      reset_req_i,
  input  logic      exc_req_i,
  input  logic      irq_req_i,
  input  logic      halted_i,
  input  logic      vbr_zero_i,
  input  exc_kind_e kind_i,
  output act_e      act_o,
  output word_t     vec_off_o,
  output logic      trap_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (reset_req_i)             act_o = ACT_RESET;
    else if (!halted_i) begin
      if (exc_req_i)             act_o = vbr_zero_i ? ACT_HALT : ACT_EXC;
      else if (irq_req_i)        act_o = ACT_IRQ;
    end
  end

  always_comb begin
    vec_off_o = VEC_GENERAL;
    if (act_o == ACT_IRQ)                          vec_off_o = VEC_IRQ;
    else if (act_o == ACT_EXC && kind_i == KIND_TLB) vec_off_o = VEC_TLB;
  end

  assign trap_o = (act_o == ACT_EXC) && (kind_i == KIND_TRAP);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import esq_pkg::*;
#(
  parameter int NUM_BANKED = 8,
  parameter int CODE_W     = 12,
  parameter int TRAP_W     = 8,
  localparam int IDX_W     = $clog2(NUM_BANKED)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       pc_i,
  input  logic              delay_slot_i,
  input  logic [31:0]       r15_i,
  input  logic              reset_req_i,
  input  logic [CODE_W-1:0] reset_code_i,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [TRAP_W-1:0] trap_imm_i,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic              sr_we_i,
  input  logic [31:0]       sr_wdata_i,
  input  logic              vbr_we_i,
  input  logic [31:0]       vbr_wdata_i,
  input  logic              gpr_we_i,
  input  logic [IDX_W-1:0]  gpr_widx_i,
  input  logic [31:0]       gpr_wdata_i,
  input  logic [IDX_W:0]    gpr_ridx_i,
  output logic [31:0]       gpr_rdata_o,
  output logic [31:0]       sr_o,
  output logic [31:0]       vbr_o,
  output logic              redirect_o,
  output logic [31:0]       new_pc_o,
  output logic [31:0]       next_pc_o,
  output logic [31:0]       spc_o,
  output logic [31:0]       ssr_o,
  output logic [31:0]       sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [TRAP_W+1:0] tra_o,
  output logic              halt_o,
  output logic              delay_clear_o
);
  act_e  act;
  word_t vec_off;
  logic  is_trap;
  logic  sr_wr_en;
  word_t sr_wr_data;
  logic  rb;

  word_t vbr_q, new_pc_q, spc_q, ssr_q, sgr_q;
  logic [CODE_W-1:0] expevt_q, intevt_q;
  logic [TRAP_W+1:0] tra_q;
  logic halt_q, redirect_q, dclr_q;

  esq_arb u_arb (
    .reset_req_i (reset_req_i),
    .exc_req_i   (exc_req_i),
    .irq_req_i   (irq_req_i),
    .halted_i    (halt_q),
    .vbr_zero_i  (vbr_q == '0),
    .kind_i      (exc_kind_e'(exc_kind_i)),
    .act_o       (act),
    .vec_off_o   (vec_off),
    .trap_o      (is_trap)
  );

  always_comb begin
    sr_wr_en   = 1'b0;
    sr_wr_data = sr_o;
    unique case (act)
      ACT_RESET: begin
        sr_wr_en   = 1'b1;
        sr_wr_data = (sr_o | SR_EVENT_SET | SR_IMASK) & ~SR_FD;
      end
      ACT_EXC, ACT_IRQ: begin
        sr_wr_en   = 1'b1;
        sr_wr_data = sr_o | SR_EVENT_SET;
      end
      ACT_NONE: begin
        sr_wr_en   = sr_we_i;
        sr_wr_data = sr_wdata_i;
      end
      default: ;
    endcase
  end

  esq_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (sr_wr_en),
    .wr_data_i (sr_wr_data),
    .sr_o      (sr_o),
    .rb_o      (rb)
  );

  esq_gpr_bank #(.NUM_BANKED(NUM_BANKED)) u_gpr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rb_i    (rb),
    .we_i    (gpr_we_i),
    .widx_i  (gpr_widx_i),
    .wdata_i (gpr_wdata_i),
    .ridx_i  (gpr_ridx_i),
    .rdata_o (gpr_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbr_q      <= '0;
      new_pc_q   <= RESET_PC;
      spc_q      <= '0;
      ssr_q      <= '0;
      sgr_q      <= '0;
      expevt_q   <= '0;
      intevt_q   <= '0;
      tra_q      <= '0;
      halt_q     <= 1'b0;
      redirect_q <= 1'b0;
      dclr_q     <= 1'b0;
    end else begin
      redirect_q <= (act == ACT_RESET) || (act == ACT_EXC) || (act == ACT_IRQ);
      dclr_q     <= (act == ACT_EXC) && delay_slot_i;
      if (vbr_we_i) vbr_q <= vbr_wdata_i;
      unique case (act)
        ACT_RESET: begin
          expevt_q <= reset_code_i;
          vbr_q    <= '0;
          new_pc_q <= RESET_PC;
          halt_q   <= 1'b0;
        end
        ACT_EXC: begin
          spc_q    <= delay_slot_i ? pc_i - 32'd2 : pc_i;
          ssr_q    <= sr_o;
          sgr_q    <= r15_i;
          expevt_q <= exc_code_i;
          new_pc_q <= vbr_q + vec_off;
          if (is_trap) tra_q <= {trap_imm_i, 2'b00};
        end
        ACT_IRQ: begin
          spc_q    <= pc_i;
          ssr_q    <= sr_o;
          sgr_q    <= r15_i;
          intevt_q <= irq_code_i;
          new_pc_q <= vbr_q + vec_off;
        end
        ACT_HALT: halt_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign vbr_o         = vbr_q;
  assign new_pc_o      = new_pc_q;
  assign next_pc_o     = new_pc_q + 32'd2;
  assign spc_o         = spc_q;
  assign ssr_o         = ssr_q;
  assign sgr_o         = sgr_q;
  assign expevt_o      = expevt_q;
  assign intevt_o      = intevt_q;
  assign tra_o         = tra_q;
  assign halt_o        = halt_q;
  assign redirect_o    = redirect_q;
  assign delay_clear_o = dclr_q;

  AST_RESET_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reset_req_i) |-> (new_pc_o == RESET_PC) && (vbr_o == '0) && !halt_o); // R8
  AST_EVENT_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (sr_o[30:28] == 3'b111)); // R2
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !reset_req_i) |=> halt_o); // R6
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !redirect_o); // R6
  AST_DELAY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_clear_o |-> redirect_o && $past(delay_slot_i) && $past(exc_req_i)); // R5
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pc, r15, sr_wd, vbr_wd, gpr_wd;
  logic ds, rreq, ereq, ireq, sr_we, vbr_we, gpr_we;
  logic [11:0] rcode, ecode, icode;
  logic [1:0] kind;
  logic [7:0] timm;
  logic [2:0] widx;
  logic [3:0] ridx;
  logic [31:0] rdata, sr, vbr, npc, nnpc, spc, ssr, sgr;
  logic [11:0] expevt, intevt;
  logic [9:0] tra;
  logic redir, halt, dclr;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .delay_slot_i(ds), .r15_i(r15),
    .reset_req_i(rreq), .reset_code_i(rcode), .exc_req_i(ereq), .exc_kind_i(kind),
    .exc_code_i(ecode), .trap_imm_i(timm), .irq_req_i(ireq), .irq_code_i(icode),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .vbr_we_i(vbr_we), .vbr_wdata_i(vbr_wd),
    .gpr_we_i(gpr_we), .gpr_widx_i(widx), .gpr_wdata_i(gpr_wd), .gpr_ridx_i(ridx),
    .gpr_rdata_o(rdata), .sr_o(sr), .vbr_o(vbr), .redirect_o(redir), .new_pc_o(npc),
    .next_pc_o(nnpc), .spc_o(spc), .ssr_o(ssr), .sgr_o(sgr), .expevt_o(expevt),
    .intevt_o(intevt), .tra_o(tra), .halt_o(halt), .delay_clear_o(dclr)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_sr, m_vbr, m_pc, m_spc, m_ssr, m_sgr;
  logic [11:0] m_exp, m_int;
  logic [9:0] m_tra;
  logic m_halt, m_redir, m_dc;
  logic [31:0] m_act [8];
  logic [31:0] m_sh [8];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ds = 0; rreq = 0; ereq = 0; ireq = 0; sr_we = 0; vbr_we = 0; gpr_we = 0;
  endtask

  function automatic logic [31:0] vec(logic [1:0] k);
    return (k == 2'd2) ? 32'h400 : 32'h100;
  endfunction

  // reference step: model the edge, then compare every output
  task automatic step();
    logic [31:0] nsr;
    logic ev, old_rb;
    nsr = m_sr;
    old_rb = m_sr[29];
    ev = rreq || (!m_halt && (ereq || ireq));
    m_redir = 0; m_dc = 0;
    if (gpr_we) m_act[widx] = gpr_wd;
    if (vbr_we && !rreq) m_vbr_next(vbr_wd);
    if (rreq) begin
      m_exp = rcode; m_vbr = 0; m_pc = 32'hA000_0000; m_halt = 0; m_redir = 1;
      nsr = (m_sr | 32'h7000_00F0) & ~32'h8000;
    end else if (!m_halt && ereq) begin
      if (m_vbr_old == 0) m_halt = 1;
      else begin
        m_spc = ds ? pc - 2 : pc; m_ssr = m_sr; m_sgr = r15; m_exp = ecode;
        if (kind == 2'd1) m_tra = {timm, 2'b00};
        m_pc = m_vbr_old + vec(kind); nsr = m_sr | 32'h7000_0000;
        m_redir = 1; m_dc = ds;
      end
    end else if (!m_halt && ireq) begin
      m_spc = pc; m_ssr = m_sr; m_sgr = r15; m_int = icode;
      m_pc = m_vbr_old + 32'h600; nsr = m_sr | 32'h7000_0000; m_redir = 1;
    end else if (sr_we && !ev) nsr = sr_wd & 32'h7000_83F3;
    m_sr = nsr;
    if (m_sr[29] != old_rb)
      for (int i = 0; i < 8; i++) begin
        logic [31:0] t;
        t = m_act[i]; m_act[i] = m_sh[i]; m_sh[i] = t;
      end
    m_vbr_old = m_vbr;
    @(posedge clk); #2;
    chk("R10 sr", sr, m_sr);
    chk("R12 vbr", vbr, m_vbr);
    chk("R2 new_pc", npc, m_pc);
    chk("R2 next_pc", nnpc, m_pc + 2);
    chk("R5 spc", spc, m_spc);
    chk("R2 ssr", ssr, m_ssr);
    chk("R2 sgr", sgr, m_sgr);
    chk("R2 expevt", {20'd0, expevt}, {20'd0, m_exp});
    chk("R7 intevt", {20'd0, intevt}, {20'd0, m_int});
    chk("R4 tra", {22'd0, tra}, {22'd0, m_tra});
    chk("R6 halt", {31'd0, halt}, {31'd0, m_halt});
    chk("R9 redirect", {31'd0, redir}, {31'd0, m_redir});
    chk("R5 delay_clear", {31'd0, dclr}, {31'd0, m_dc});
    chk("R11 gpr", rdata, ridx[3] ? m_sh[ridx[2:0]] : m_act[ridx[2:0]]);
  endtask

  logic [31:0] m_vbr_old;
  task automatic m_vbr_next(logic [31:0] v);
    m_vbr = v;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    idle();
    pc = 0; r15 = 0; sr_wd = 0; vbr_wd = 0; gpr_wd = 0; rcode = 0; ecode = 0;
    icode = 0; kind = 0; timm = 0; widx = 0; ridx = 0;
    m_sr = 32'h7000_00F0; m_vbr = 0; m_vbr_old = 0; m_pc = 32'hA000_0000;
    m_spc = 0; m_ssr = 0; m_sgr = 0; m_exp = 0; m_int = 0; m_tra = 0;
    m_halt = 0; m_redir = 0; m_dc = 0;
    for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_sh[i] = 0; end
    #45 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sr", sr, 32'h7000_00F0);
    chk("R1 new_pc", npc, 32'hA000_0000);
    chk("R1 next_pc", nnpc, 32'hA000_0002);
    step();
    // R12 program vector base
    vbr_we = 1; vbr_wd = 32'h8C00_0000; step(); idle();
    // R2 and R5: exception in delay slot
    ereq = 1; kind = 0; ecode = 12'h1E0; ds = 1; pc = 32'h8C00_1234; r15 = 32'h8CFF_FF00;
    step(); idle();
    chk("R5 spc minus 2", spc, 32'h8C00_1232);
    step();
    // R4 trap
    ereq = 1; kind = 1; ecode = 12'h160; timm = 8'hA5; pc = 32'h8C00_2000; step(); idle();
    chk("R4 tra value", {22'd0, tra}, 32'h294);
    // R3 TLB miss
    ereq = 1; kind = 2; ecode = 12'h040; step(); idle();
    chk("R3 tlb vector", npc, 32'h8C00_0400);
    // R9 exception beats interrupt; R7 interrupt alone ignores delay flag
    ereq = 1; kind = 3; ecode = 12'h0E0; ireq = 1; icode = 12'h320; step(); idle();
    ireq = 1; icode = 12'h340; ds = 1; pc = 32'h8C00_3000; step(); idle();
    chk("R7 irq vector", npc, 32'h8C00_0600);
    // R11 bank exchange via status write
    for (int i = 0; i < 8; i++) begin
      gpr_we = 1; widx = 3'(i); gpr_wd = 32'h1000 + i; ridx = 4'(i); step();
    end
    idle(); sr_we = 1; sr_wd = 32'h4000_0303; ridx = 4'd8; step(); idle();
    chk("R11 old set at upper index", rdata, 32'h1000);
    sr_we = 1; sr_wd = 32'h6000_0000; ireq = 1; step(); idle();
    // R6 halt on zero vector base, events ignored, reset request escapes
    vbr_we = 1; vbr_wd = 0; step(); idle();
    ereq = 1; kind = 0; step(); idle();
    ireq = 1; step(); idle();
    ereq = 1; step(); idle();
    rreq = 1; rcode = 12'h020; ereq = 1; ireq = 1; step(); idle();
    chk("R8 reset pc", npc, 32'hA000_0000);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      rreq   = ($urandom_range(0, 29) == 0);
      ereq   = ($urandom_range(0, 3) == 0);
      ireq   = ($urandom_range(0, 3) == 0);
      sr_we  = ($urandom_range(0, 5) == 0);
      vbr_we = ($urandom_range(0, 9) == 0);
      gpr_we = $urandom_range(0, 1) == 1;
      ds     = $urandom_range(0, 1) == 1;
      kind   = 2'($urandom_range(0, 3));
      pc = $urandom; r15 = $urandom; sr_wd = $urandom; gpr_wd = $urandom;
      vbr_wd = ($urandom_range(0, 7) == 0) ? 32'd0 : ($urandom & 32'hFFFF_F000);
      rcode = 12'($urandom); ecode = 12'($urandom); icode = 12'($urandom);
      timm = 8'($urandom); widx = 3'($urandom); ridx = 4'($urandom);
      step();
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule